// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a down-counting watchdog that only accepts a refresh late in its period. While it is enabled, it counts down from a programmed period value toward zero. Software must refresh it inside an acceptance window at the end of each period. A refresh that comes too early is an illegal write. Letting the count run out is an underflow. Both kinds of fault raise the same response.

A mode input selects that response. It is either a latched interrupt that stays high until acknowledged, or a single-cycle reset pulse. A 2-bit code sets the window width as a quarter, half, three quarters or all of the period. Sticky flags record the cause of the latest fault and any refresh attempted while the counter is not running. A clear strobe resets these flags.

Top module: `win_wdog`

## Requirements
- R1: While `rst_n` is low, every output is 0: `running`, `count`, `wdt_irq`, `wdt_rst` and all status flags.
- R2: With `en` high and `running` low, a clock edge loads `count` with `period` and sets `running`. At an edge where `en` is low, `running` clears and `count` holds its value.
- R3: At each edge where the counter is running, `en` is high and no refresh is present, `count` drops by one. At such an edge with `count` equal to 0, an underflow fault occurs: `count` reloads the captured period and `st_underflow` is set.
- R4: The window threshold is floor(P*(S+1)/4), where P is the captured period and S is the captured code. Code 00 gives 25%, 01 gives 50%, 10 gives 75% and 11 gives 100%. A refresh is legal when `count` is at or below the threshold, so the window is the last part of the period.
- R5: A legal refresh reloads `count` with the captured period and raises no fault.
- R6: An illegal refresh (`count` above the threshold while running) is a fault. It reloads `count` and sets `st_illegal`.
- R7: With `fault_mode` = 0, a fault sets `wdt_irq` at the next edge. `wdt_irq` stays high until an edge with `irq_ack` and no new fault; a fault wins over a simultaneous acknowledge.
- R8: With `fault_mode` = 1, a fault gives a `wdt_rst` pulse one cycle long per faulting edge and leaves `wdt_irq` untouched.
- R9: On a fault, exactly one cause flag is set: `st_underflow` or `st_illegal`, and the other is cleared. `clr_status` clears both flags and `st_misuse`, but a fault or misuse at the same edge takes priority.
- R10: A refresh at an edge where `en` or `running` is low has no effect on `count`, `running` or the fault outputs. Instead it sets `st_misuse`.
- R11: `period` and `win_sel` are captured when counting starts. Changing them while the counter runs has no effect on the count or the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable; a rising level starts a new period |
| period | input | CNT_W | Period length in cycles, captured at start; must be nonzero |
| win_sel | input | 2 | Window code, captured at start |
| refresh_wr | input | 1 | Refresh register write strobe |
| fault_mode | input | 1 | 0 selects the interrupt response, 1 selects the reset response |
| irq_ack | input | 1 | Interrupt acknowledge |
| clr_status | input | 1 | Clears the sticky status flags |
| running | output | 1 | Counter active |
| count | output | CNT_W | Current count value |
| wdt_irq | output | 1 | Latched watchdog interrupt |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |
| st_underflow | output | 1 | Latest fault was an underflow |
| st_illegal | output | 1 | Latest fault was an illegal refresh |
| st_misuse | output | 1 | A refresh arrived while the counter was not running |

## Verification
Every result is registered, so each output reflects the stimulus sampled at one rising edge, one cycle later. This covers the reload, the decrement, the interrupt, the reset pulse and each flag. The bench changes inputs one time unit after a rising edge. A behavioural model advances at that same edge, and the outputs are compared at the falling edge, halfway through the cycle that follows. Directed checks are placed in the same way: a strobe is driven for exactly one edge, and its effect is read one edge later. This places boundary refreshes, at the threshold and one count above it, on the exact cycle they target.

// File: rtl/win_wdog.sv
module win_wdog #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  input  logic [1:0]       win_sel,
  input  logic             refresh_wr,
  input  logic             fault_mode,
  input  logic             irq_ack,
  input  logic             clr_status,
  output logic             running,
  output logic [CNT_W-1:0] count,
  output logic             wdt_irq,
  output logic             wdt_rst,
  output logic             st_underflow,
  output logic             st_illegal,
  output logic             st_misuse
);

  localparam int PROD_W = CNT_W + 3;

  logic             run_q;
  logic [CNT_W-1:0] cnt_q, per_q, thr_q;
  logic [PROD_W-1:0] prod;
  logic             start, active, in_win, ok_ref, bad_ref, uflow, fault, misuse;

  assign prod    = PROD_W'(period) * (PROD_W'(win_sel) + PROD_W'(1));
  assign start   = en && !run_q;
  assign active  = en && run_q;
  assign in_win  = cnt_q <= thr_q;
  assign ok_ref  = active && refresh_wr && in_win;
  assign bad_ref = active && refresh_wr && !in_win;
  assign uflow   = active && !refresh_wr && (cnt_q == '0);
  assign fault   = bad_ref || uflow;
  assign misuse  = refresh_wr && !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      per_q <= '0;
      thr_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= period;
      per_q <= period;
      thr_q <= prod[CNT_W+1:2];
    end else if (active) begin
      if (ok_ref || fault) cnt_q <= per_q;
      else                 cnt_q <= cnt_q - 1'b1;
    end else begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdt_irq      <= 1'b0;
      wdt_rst      <= 1'b0;
      st_underflow <= 1'b0;
      st_illegal   <= 1'b0;
      st_misuse    <= 1'b0;
    end else begin
      wdt_rst <= fault && fault_mode;
      if (fault && !fault_mode) wdt_irq <= 1'b1;
      else if (irq_ack)         wdt_irq <= 1'b0;
      if (fault) begin
        st_underflow <= uflow;
        st_illegal   <= bad_ref;
      end else if (clr_status) begin
        st_underflow <= 1'b0;
        st_illegal   <= 1'b0;
      end
      if (misuse)          st_misuse <= 1'b1;
      else if (clr_status) st_misuse <= 1'b0;
    end
  end

  assign running = run_q;
  assign count   = cnt_q;

endmodule

// File: rtl/win_wdog_chk.sv
module win_wdog_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [CNT_W-1:0] period,
  input logic [1:0]       win_sel,
  input logic             refresh_wr,
  input logic             fault_mode,
  input logic             irq_ack,
  input logic             clr_status,
  input logic             running,
  input logic [CNT_W-1:0] count,
  input logic             wdt_irq,
  input logic             wdt_rst,
  input logic             st_underflow,
  input logic             st_illegal,
  input logic             st_misuse
);

  always_comb begin
    if (!rst_n) AST_RESET_QUIET: assert (!running && !wdt_irq && !wdt_rst && !st_misuse); // R1
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    running && en && !refresh_wr && count != '0 |=> count == $past(count) - 1); // R3

  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    running && en && !refresh_wr && count == '0 |=> st_underflow && !st_illegal); // R3

  AST_CAUSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_underflow && st_illegal)); // R9

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_irq && !irq_ack |=> wdt_irq); // R7

  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (st_underflow || st_illegal) && $past(fault_mode)); // R8

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !running && $stable(count)); // R10

  AST_MISUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_wr && !(en && running) |=> st_misuse); // R10

endmodule

bind win_wdog win_wdog_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/win_wdog_bench.sv
module win_wdog_bench;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [CNT_W-1:0] period = 16'd20;
  logic [1:0] win_sel = 2'b00;
  logic refresh_wr = 1'b0, fault_mode = 1'b0, irq_ack = 1'b0, clr_status = 1'b0;
  logic running, wdt_irq, wdt_rst, st_underflow, st_illegal, st_misuse;
  logic [CNT_W-1:0] count;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  win_wdog #(.CNT_W(CNT_W)) u_win_wdog (.*);

  // behavioural reference model
  bit m_run, m_irq, m_rst, m_uf, m_ill, m_mis;
  int m_cnt, m_per, m_sel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_per = 0; m_sel = 0;
      m_irq = 0; m_rst = 0; m_uf = 0; m_ill = 0; m_mis = 0;
    end else begin
      bit flt, why_uf, why_ill, abuse;
      flt = 0; why_uf = 0; why_ill = 0; abuse = 0;
      if (en && !m_run) begin
        abuse = refresh_wr;
        m_run = 1; m_per = int'(period); m_cnt = m_per; m_sel = int'(win_sel);
      end else if (en) begin
        if (refresh_wr) begin
          if (m_cnt * 4 > m_per * (m_sel + 1)) begin flt = 1; why_ill = 1; end
          m_cnt = m_per;
        end else if (m_cnt == 0) begin
          flt = 1; why_uf = 1; m_cnt = m_per;
        end else m_cnt = m_cnt - 1;
      end else begin
        abuse = refresh_wr;
        m_run = 0;
      end
      m_rst = flt && fault_mode;
      if (flt && !fault_mode) m_irq = 1; else if (irq_ack) m_irq = 0;
      if (flt) begin m_uf = why_uf; m_ill = why_ill; end
      else if (clr_status) begin m_uf = 0; m_ill = 0; end
      if (abuse) m_mis = 1; else if (clr_status) m_mis = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 running", running, m_run);
    chk("R3 count", count, m_cnt);
    chk("R7 wdt_irq", wdt_irq, m_irq);
    chk("R8 wdt_rst", wdt_rst, m_rst);
    chk("R9 st_underflow", st_underflow, m_uf);
    chk("R9 st_illegal", st_illegal, m_ill);
    chk("R10 st_misuse", st_misuse, m_mis);
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_refresh();
    refresh_wr = 1'b1; step(); refresh_wr = 1'b0;
  endtask

  task automatic wait_count(int v);
    while (count != CNT_W'(v)) step();
  endtask

  task automatic restart(logic [1:0] code, int p);
    en = 1'b0; step(); win_sel = code; period = CNT_W'(p); en = 1'b1; step();
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 running at reset", running, 0);
    chk("R1 count at reset", count, 0);
    chk("R1 flags at reset", {wdt_irq, wdt_rst, st_underflow, st_illegal, st_misuse}, 0);
    rst_n = 1'b1; step();

    pulse_refresh();                                // R10 stopped refresh
    chk("R10 misuse flag", st_misuse, 1);
    chk("R10 count untouched", count, 0);
    chk("R10 no irq", wdt_irq, 0);
    clr_status = 1'b1; step(); clr_status = 1'b0;
    chk("R9 clear misuse", st_misuse, 0);

    win_sel = 2'b00; period = 16'd20; en = 1'b1; step();
    chk("R2 load period", count, 20);
    chk("R2 running set", running, 1);
    step();
    chk("R3 decrement", count, 19);

    wait_count(5); pulse_refresh();                 // threshold 5 for code 00
    chk("R5 legal refresh reload", count, 20);
    chk("R5 no fault", wdt_irq, 0);

    wait_count(6); pulse_refresh();
    chk("R6 illegal refresh flag", st_illegal, 1);
    chk("R7 irq raised", wdt_irq, 1);
    chk("R6 reload after fault", count, 20);
    step(2);
    chk("R7 irq held", wdt_irq, 1);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    chk("R7 irq acked", wdt_irq, 0);

    fault_mode = 1'b1;
    wait_count(0); step();
    chk("R3 underflow flag", st_underflow, 1);
    chk("R9 other cause cleared", st_illegal, 0);
    chk("R8 reset pulse", wdt_rst, 1);
    chk("R8 irq untouched", wdt_irq, 0);
    step();
    chk("R8 pulse ends", wdt_rst, 0);
    clr_status = 1'b1; step(); clr_status = 1'b0;
    chk("R9 clear causes", st_underflow, 0);

    restart(2'b01, 20); wait_count(11); pulse_refresh();
    chk("R4 code 01 above threshold", st_illegal, 1);
    wait_count(10); pulse_refresh();
    chk("R4 code 01 at threshold", wdt_rst, 0);
    restart(2'b10, 20); wait_count(16); pulse_refresh();
    chk("R4 code 10 above threshold", wdt_rst, 1);
    wait_count(15); pulse_refresh();
    chk("R4 code 10 at threshold", wdt_rst, 0);
    restart(2'b11, 20); pulse_refresh();
    chk("R4 code 11 whole period", wdt_rst, 0);
    chk("R4 code 11 reload", count, 20);

    fault_mode = 1'b0;
    restart(2'b00, 20);
    win_sel = 2'b11; period = 16'd40; step();
    chk("R11 period ignored", count, 19);
    wait_count(15); pulse_refresh();
    chk("R11 old window kept", wdt_irq, 1);
    irq_ack = 1'b1; wait_count(6); refresh_wr = 1'b1; step(); refresh_wr = 1'b0; irq_ack = 1'b0;
    chk("R7 fault beats ack", wdt_irq, 1);

    en = 1'b0; step();
    chk("R2 stop", running, 0);
    begin
      int held;
      held = int'(count);
      pulse_refresh();
      chk("R10 stopped count held", count, held);
      chk("R10 misuse on stopped refresh", st_misuse, 1);
    end

    begin
      logic [7:0] lf = 8'hA5;
      en = 1'b1; period = 16'd9; win_sel = 2'b01;
      for (int i = 0; i < 3000; i++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        refresh_wr = (lf[2:0] == 3'd0);
        irq_ack    = lf[3] & lf[6];
        clr_status = (lf[7:5] == 3'd7);
        fault_mode = lf[4];
        en         = (lf != 8'h3C);
        win_sel    = lf[1:0];
        period     = CNT_W'(1 + lf[6:3]);
        step();
      end
      refresh_wr = 1'b0; irq_ack = 1'b0; clr_status = 1'b0;
    end

    step(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule